// File: doc/BRIEF.md
# Register-Mapped Multiply Controller

This block is a memory-mapped slave that fronts an external multiply engine through five 32-bit registers. Software writes two operands, sets a start bit, and later reads back a product and a small set of condition flags. The engine sits outside the block and connects through a start/done port pair. The block gives it a one-cycle start pulse and holds its operands steady. It waits for a one-cycle done pulse that carries the product and the flags.

The slave address counts whole 32-bit words, so a master byte address shifted right by two gives the offset. Transfers with no stall take one cycle. Once a multiply is under way, the block holds its wait line high. Every read or write that arrives during the run is held off until the product has been stored.

Top module: `mm_mult_slave`

## Requirements
- R1: Offset 0 holds operand A and offset 1 holds operand B. Both read back the last value written to them.
- R2: Offset 4 (status) holds the engine flags in bits 3..0, with bit 3 overflow, bit 2 underflow, bit 1 zero and bit 0 NaN, taken from `eng_flags` in the same bit order. Bits 31..4 read as zero.
- R3: An accepted write to offset 2 with bit 0 set drives `eng_start` high for exactly one cycle, in the cycle after the write edge. `eng_op_a` and `eng_op_b` carry the stored operands at that time. A write to offset 2 with bit 0 clear starts nothing.
- R4: Bit 0 of offset 2 reads 1 while a multiply is in progress and 0 when the block is idle. Bits 31..1 read as zero.
- R5: `bus_wait` rises in the cycle after the start write is accepted. It stays high until the done pulse has been taken, so it is high for the engine latency plus one cycle.
- R6: On the edge at which `eng_done` is high, `eng_product` is stored at offset 3 and `eng_flags` at offset 4. In the next cycle the busy bit and `bus_wait` are both low.
- R7: With `bus_wait` low, `bus_rdata` is valid in the same cycle as `bus_read` and the address, and a write is captured at the next rising edge.
- R8: A write issued during a stall is captured only after `bus_wait` falls. Operands written this way do not alter the multiply already in flight.
- R9: A synchronous active-high reset clears every register, `bus_wait` and `eng_start`, including during a multiply.
- R10: Writes to offsets 3, 4, 5, 6 and 7 change nothing. Reads of offsets 5, 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word offset of the register |
| bus_read | input | 1 | Read strobe |
| bus_write | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| bus_wait | output | 1 | Stall request to the master |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_op_a | output | 32 | Operand A to the engine |
| eng_op_b | output | 32 | Operand B to the engine |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_product | input | 32 | Engine product, valid with `eng_done` |
| eng_flags | input | 4 | Engine flags {overflow, underflow, zero, NaN}, valid with `eng_done` |

## Verification
A busy flag stuck high or cleared early shows at the ports within one cycle. `bus_wait` then either stays high past the engine latency plus one cycle, or it drops before the product register has been loaded. Either way, a stalled read returns stale data. A corrupted operand or mis-decoded offset appears in the first readback of that register or in the stored product. A missing or doubled start pulse shows up as a wait period of the wrong length, or as a second engine launch, before the next transfer completes.

// File: rtl/mmm_pkg.sv
package mmm_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int FLAG_W = 4;

  localparam logic [ADDR_W-1:0] OFF_OPA  = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_OPB  = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_RES  = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd4;

  // flag order is part of the status register layout
  typedef struct packed {
    logic ovf;
    logic unf;
    logic zer;
    logic nan;
  } flags_t;
endpackage

// File: rtl/mmm_ctrl.sv
module mmm_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic eng_done,
  output logic busy,
  output logic start_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= start_req;
      if (start_req)
        busy <= 1'b1;
      else if (eng_done && busy)
        busy <= 1'b0;
    end
  end
endmodule

// File: rtl/mmm_regs.sv
module mmm_regs
  import mmm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int FW = FLAG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          cap_en,
  input  logic [DW-1:0] cap_product,
  input  logic [FW-1:0] cap_flags,
  output logic [DW-1:0] op_a,
  output logic [DW-1:0] op_b,
  output logic [DW-1:0] result,
  output logic [FW-1:0] status
);
  localparam int NUM_OPS = 2;
  logic [DW-1:0] ops [NUM_OPS];

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    always_ff @(posedge clk) begin
      if (rst)
        ops[i] <= '0;
      else if (wr_en && wr_addr == AW'(i))
        ops[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      status <= '0;
    end else if (cap_en) begin
      result <= cap_product;
      status <= cap_flags;
    end
  end

  assign op_a = ops[0];
  assign op_b = ops[1];
endmodule

// File: rtl/mmm_rdmux.sv
module mmm_rdmux
  import mmm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int FW = FLAG_W
) (
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          busy,
  input  logic [DW-1:0] result,
  input  logic [FW-1:0] status,
  output logic [DW-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (rd_addr)
        OFF_OPA:  rd_data = op_a;
        OFF_OPB:  rd_data = op_b;
        OFF_CTRL: rd_data = DW'(busy);
        OFF_RES:  rd_data = result;
        OFF_STAT: rd_data = DW'(status);
        default:  rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/mm_mult_slave.sv
module mm_mult_slave
  import mmm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_read,
  input  logic              bus_write,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_wait,
  output logic              eng_start,
  output logic [DATA_W-1:0] eng_op_a,
  output logic [DATA_W-1:0] eng_op_b,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_product,
  input  logic [FLAG_W-1:0] eng_flags
);
  logic              busy;
  logic              wr_ok;
  logic              start_req;
  logic              cap_en;
  logic [DATA_W-1:0] result;
  logic [FLAG_W-1:0] status;

  // a write is taken only when the bus is not stalled
  assign wr_ok     = bus_write && !busy;
  assign start_req = wr_ok && bus_addr == OFF_CTRL && bus_wdata[0];
  assign cap_en    = busy && eng_done;

  mmm_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_req   (start_req),
    .eng_done    (eng_done),
    .busy        (busy),
    .start_pulse (eng_start)
  );

  mmm_regs #(.DW(DATA_W), .AW(ADDR_W), .FW(FLAG_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_ok),
    .wr_addr     (bus_addr),
    .wr_data     (bus_wdata),
    .cap_en      (cap_en),
    .cap_product (eng_product),
    .cap_flags   (eng_flags),
    .op_a        (eng_op_a),
    .op_b        (eng_op_b),
    .result      (result),
    .status      (status)
  );

  mmm_rdmux #(.DW(DATA_W), .AW(ADDR_W), .FW(FLAG_W)) u_rdmux (
    .rd_en   (bus_read),
    .rd_addr (bus_addr),
    .op_a    (eng_op_a),
    .op_b    (eng_op_b),
    .busy    (busy),
    .result  (result),
    .status  (status),
    .rd_data (bus_rdata)
  );

  assign bus_wait = busy;
endmodule

// File: rtl/mmm_checker.sv
module mmm_checker
  import mmm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_read,
  input logic              bus_write,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_wait,
  input logic              eng_start,
  input logic [DATA_W-1:0] eng_op_a,
  input logic [DATA_W-1:0] eng_op_b,
  input logic              eng_done
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start); // R3
  AST_START_RAISES_WAIT: assert property (@(posedge clk) disable iff (rst)
    (bus_write && !bus_wait && bus_addr == OFF_CTRL && bus_wdata[0]) |=> (bus_wait && eng_start)); // R5
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (bus_wait && !eng_done) |=> bus_wait); // R5
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (bus_wait && eng_done) |=> !bus_wait); // R6
  AST_OPS_STEADY: assert property (@(posedge clk) disable iff (rst)
    bus_wait |=> ($stable(eng_op_a) && $stable(eng_op_b))); // R8
  AST_STATUS_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_read && bus_addr == OFF_STAT) |-> bus_rdata[DATA_W-1:FLAG_W] == '0); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_read && bus_addr > OFF_STAT) |-> bus_rdata == '0); // R10
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!bus_wait && !eng_start)); // R9
endmodule

bind mm_mult_slave mmm_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_read  (bus_read),
  .bus_write (bus_write),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_wait  (bus_wait),
  .eng_start (eng_start),
  .eng_op_a  (eng_op_a),
  .eng_op_b  (eng_op_b),
  .eng_done  (eng_done)
);

// File: tb/mm_mult_slave_test.sv
module mm_mult_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_read = 1'b0;
  logic        bus_write = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_wait;
  logic        eng_start;
  logic [31:0] eng_op_a, eng_op_b;
  logic        eng_done;
  logic [31:0] eng_product;
  logic [3:0]  eng_flags;

  int checks = 0;
  int fails = 0;
  int starts = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_mult_slave uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_read(bus_read),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_wait(bus_wait), .eng_start(eng_start), .eng_op_a(eng_op_a),
    .eng_op_b(eng_op_b), .eng_done(eng_done), .eng_product(eng_product),
    .eng_flags(eng_flags)
  );

  // fixed-latency engine stub: samples operands on start
  function automatic logic [31:0] f_prod(logic [31:0] a, logic [31:0] b);
    return a * b + 32'h1357;
  endfunction
  function automatic logic [3:0] f_flags(logic [31:0] a, logic [31:0] b);
    return {a[31], b[31], (a == 0 || b == 0), a[0] & b[0]};
  endfunction

  int unsigned stub_cnt = 0;
  logic [31:0] stub_a = '0, stub_b = '0;
  always_ff @(posedge clk) begin
    if (eng_start) begin
      stub_cnt <= LAT;
      stub_a   <= eng_op_a;
      stub_b   <= eng_op_b;
      starts   <= starts + 1;
    end else if (stub_cnt != 0) begin
      stub_cnt <= stub_cnt - 1;
    end
  end
  assign eng_done    = (stub_cnt == 1);
  assign eng_product = eng_done ? f_prod(stub_a, stub_b) : 32'hDEAD_BEEF;
  assign eng_flags   = eng_done ? f_flags(stub_a, stub_b) : 4'hF;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_write = 1'b1;
    #1;
    while (bus_wait) begin @(negedge clk); #1; end
    @(negedge clk);
    bus_write = 1'b0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_read = 1'b1;
    #1;
    while (bus_wait) begin @(negedge clk); #1; end
    d = bus_rdata;
    @(negedge clk);
    bus_read = 1'b0;
  endtask

  // returns after start is accepted, with the count of stalled cycles
  task automatic wait_cycles(output int n);
    n = 0;
    while (bus_wait && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin : main
    logic [31:0] rd;
    int n;
    int s0;
    logic [31:0] av [6] = '{32'h0000_0003, 32'h8000_0001, 32'h0, 32'hFFFF_FFFF, 32'h1234_5678, 32'h7FFF_0001};
    logic [31:0] bv [6] = '{32'h0000_0005, 32'h8000_0003, 32'h9, 32'hFFFF_FFFF, 32'h0BAD_F00D, 32'h0000_0000};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9: reset state
    check("R9 wait after reset", {31'b0, bus_wait}, 32'd0);
    for (int k = 0; k < 8; k++) begin
      bus_rd(3'(k), rd);
      check("R9 reset readback", rd, 32'd0);
    end

    // R1 / R7: operand readback sweep
    for (int k = 0; k < 4; k++) begin
      bus_wr(3'd0, 32'hA5A5_0000 + k);
      bus_wr(3'd1, 32'h0F0F_1000 ^ (k << 8));
      bus_rd(3'd0, rd); check("R1 R7 opA", rd, 32'hA5A5_0000 + k);
      bus_rd(3'd1, rd); check("R1 R7 opB", rd, 32'h0F0F_1000 ^ (k << 8));
    end

    // R3..R6, R2: multiply sweep
    for (int k = 0; k < 6; k++) begin
      bus_wr(3'd0, av[k]);
      bus_wr(3'd1, bv[k]);
      s0 = starts;
      bus_wr(3'd2, 32'h1);
      // R4: busy bit visible on readdata during stall
      bus_addr = 3'd2; bus_read = 1'b1; #1;
      check("R4 busy bit during run", bus_rdata, 32'd1);
      bus_read = 1'b0;
      wait_cycles(n);
      check("R5 wait length", n, LAT + 1);
      check("R3 single engine start", starts - s0, 1);
      bus_rd(3'd2, rd); check("R4 R6 busy clear", rd, 32'd0);
      bus_rd(3'd3, rd); check("R6 product", rd, f_prod(av[k], bv[k]));
      bus_rd(3'd4, rd); check("R2 status flags", rd, {28'b0, f_flags(av[k], bv[k])});
    end

    // R8: write during stall waits and does not disturb flight
    bus_wr(3'd0, 32'd7);
    bus_wr(3'd1, 32'd11);
    bus_wr(3'd2, 32'h1);
    bus_wr(3'd0, 32'd100);
    check("R8 stalled write after release", {31'b0, bus_wait}, 32'd0);
    bus_rd(3'd3, rd); check("R8 product uses old operands", rd, f_prod(32'd7, 32'd11));
    bus_rd(3'd0, rd); check("R8 stalled write landed", rd, 32'd100);

    // R3: bit0 clear starts nothing
    s0 = starts;
    bus_wr(3'd2, 32'hFFFF_FFFE);
    repeat (2) @(negedge clk);
    check("R3 no start on zero bit", starts - s0, 0);
    check("R3 no stall on zero bit", {31'b0, bus_wait}, 32'd0);

    // R10: ignored writes, zero reads
    for (int k = 3; k < 8; k++) bus_wr(3'(k), 32'h5555_AAAA);
    bus_rd(3'd3, rd); check("R10 result unchanged", rd, f_prod(32'd7, 32'd11));
    bus_rd(3'd4, rd); check("R10 status unchanged", rd, {28'b0, f_flags(32'd7, 32'd11)});
    for (int k = 5; k < 8; k++) begin
      bus_rd(3'(k), rd); check("R10 unmapped read", rd, 32'd0);
    end

    // R9: reset during a run
    bus_wr(3'd2, 32'h1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R9 wait cleared mid-run", {31'b0, bus_wait}, 32'd0);
    bus_rd(3'd0, rd); check("R9 opA cleared", rd, 32'd0);
    bus_rd(3'd3, rd); check("R9 result cleared", rd, 32'd0);
    repeat (LAT + 2) @(negedge clk);
    bus_rd(3'd3, rd); check("R9 late done ignored", rd, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule